// File: doc/BRIEF.md
# Serial DMA Channel Request Agent

This block sits on the peripheral side of a two-wire serial channel-passing scheme used to ask a central DMA controller for service. Local peripherals raise one level-sensitive request line per DMA channel. The block turns that set of lines into a serial frame on an active-low request pin. Each frame is a low start bit followed by one clock per channel slot, from channel 0 up to channel 7. A channel that wants service drives its slot high.

A second, independent path watches the active-low grant pin. When the pin drops low, that clock is a start bit. The next three clocks carry the granted channel number, least significant bit first. The block then gives the local logic a one-clock strobe carrying the decoded channel. If the grant names a channel that has no local request pending, the block raises an error strobe instead.

Top module: `sdma_agent`

## Requirements
- R1: After reset, `req_n_o` is high and `gnt_valid_o` and `gnt_err_o` are low.
- R2: A frame is one clock with `req_n_o` low, then eight clocks in which slot i (i = 0 first, up to 7) drives `req_n_o` to bit i of the request set captured when the frame began. After the frame the pin returns high. With requests changed on the clock edge E0, the start bit appears in the cycle after E0.
- R3: A frame starts only when `chan_req_i` differs from the set carried by the last frame. The value before any frame counts as all zero. Holding an unchanged set, including all zero from reset, sends nothing.
- R4: A change of `chan_req_i` during a frame does not alter that frame. The pin is then high for exactly one clock, and a new frame carrying the new set follows.
- R5: `req_n_o` is high whenever no frame is being sent.
- R6: A low on `gnt_n_i` while the decoder is idle is a start bit. The next three clocks give b0, b1, b2, and the channel is b0 + 2*b1 + 4*b2. For example 1,0,0 gives 1 and 0,1,1 gives 6. `gnt_chan_o` holds the channel and a strobe lasts one clock, in the cycle after b2 is sampled.
- R7: If bit `gnt_chan_o` of `chan_req_i` is high when b2 is sampled, the strobe is `gnt_valid_o`. Otherwise the strobe is `gnt_err_o`, and `gnt_valid_o` stays low.
- R8: Grant decoding works while a request frame is being sent, and neither path disturbs the other.
- R9: `gnt_valid_o` and `gnt_err_o` are never high together. A start bit in the clock right after b2 begins a new grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both serial pins |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_req_i | input | 8 | Per-channel request level from local peripherals |
| req_n_o | output | 1 | Serial request pin, idles high |
| gnt_n_i | input | 1 | Serial grant pin, idles high |
| gnt_valid_o | output | 1 | One-clock strobe for a grant on a pending channel |
| gnt_chan_o | output | 3 | Decoded granted channel number |
| gnt_err_o | output | 1 | One-clock strobe for a grant on a channel with no pending request |

## Verification
The hardest case to reach is a request set that changes while a frame is still being shifted out. The bench changes `chan_req_i` in the middle of a frame and checks that the remaining slots still carry the old set. It then checks for exactly one idle clock, followed by a full frame of the new set. A second hard case is a grant arriving during a frame. The bench runs a frame check and a grant sequence in parallel threads that start on the same clock, and both must come out correct. Grants sent back to back, with no idle clock between them, test the decoder's return to idle.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
    localparam int NUM_CH = 8;
    localparam int CH_W   = $clog2(NUM_CH);

    typedef enum logic [1:0] {TX_IDLE, TX_START, TX_SLOT} tx_phase_e;
    typedef enum logic       {RX_IDLE, RX_BITS}           rx_phase_e;
endpackage

// File: rtl/sdma_req_ser.sv
module sdma_req_ser
    import sdma_pkg::*;
#(
    parameter int N = NUM_CH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    output logic         pin_o
);
    localparam int IW = $clog2(N);

    typedef struct packed {
        tx_phase_e     ph;
        logic [IW-1:0] idx;
        logic [N-1:0]  frame;
        logic [N-1:0]  sent;
        logic          pin;
    } ser_st_t;

    ser_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.ph)
            TX_IDLE: begin
                st_d.pin = 1'b1;
                if (req_i != st_q.sent) begin
                    st_d.ph    = TX_START;
                    st_d.frame = req_i;
                    st_d.sent  = req_i;
                    st_d.pin   = 1'b0;
                end
            end
            TX_START: begin
                st_d.ph  = TX_SLOT;
                st_d.idx = '0;
                st_d.pin = st_q.frame[0];
            end
            TX_SLOT: begin
                if (st_q.idx == IW'(N-1)) begin
                    st_d.ph  = TX_IDLE;
                    st_d.pin = 1'b1;
                end else begin
                    st_d.idx = st_q.idx + 1'b1;
                    st_d.pin = st_q.frame[st_q.idx + 1'b1];
                end
            end
            default: begin
                st_d.ph  = TX_IDLE;
                st_d.pin = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ph    <= TX_IDLE;
            st_q.idx   <= '0;
            st_q.frame <= '0;
            st_q.sent  <= '0;
            st_q.pin   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign pin_o = st_q.pin;

    // R5: pin idles high outside a frame
    p_idle_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == TX_IDLE) |-> pin_o);
    // R2: start bit is followed by slot 0
    p_start_then_slot0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == TX_START) |=> (st_q.ph == TX_SLOT && st_q.idx == '0));
    // R2: each slot shows its captured channel bit
    p_slot_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == TX_SLOT) |-> (pin_o == st_q.frame[st_q.idx]));
    // R4: a frame only begins from idle
    p_start_from_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == TX_START) |-> ($past(st_q.ph) == TX_IDLE));
    // R4: captured set is frozen during the frame
    p_frame_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == TX_SLOT) |-> $stable(st_q.frame));
endmodule

// File: rtl/sdma_gnt_dec.sv
module sdma_gnt_dec
    import sdma_pkg::*;
#(
    parameter int N = NUM_CH
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pin_i,
    input  logic [N-1:0]         pend_i,
    output logic                 valid_o,
    output logic [$clog2(N)-1:0] chan_o,
    output logic                 err_o
);
    localparam int CW   = $clog2(N);
    localparam int CNTW = (CW > 1) ? $clog2(CW) : 1;

    typedef struct packed {
        rx_phase_e       ph;
        logic [CW-1:0]   sh;
        logic [CNTW-1:0] cnt;
        logic            valid;
        logic            err;
        logic [CW-1:0]   chan;
    } dec_st_t;

    dec_st_t st_d, st_q;
    logic [CW-1:0] sh_nxt;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.err   = 1'b0;
        sh_nxt     = (st_q.sh >> 1) | (CW'(pin_i) << (CW-1));
        unique case (st_q.ph)
            RX_IDLE: begin
                if (!pin_i) begin
                    st_d.ph  = RX_BITS;
                    st_d.cnt = '0;
                end
            end
            RX_BITS: begin
                st_d.sh = sh_nxt;
                if (st_q.cnt == CNTW'(CW-1)) begin
                    st_d.ph   = RX_IDLE;
                    st_d.chan = sh_nxt;
                    if (pend_i[sh_nxt]) st_d.valid = 1'b1;
                    else                st_d.err   = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            default: st_d.ph = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ph    <= RX_IDLE;
            st_q.sh    <= '0;
            st_q.cnt   <= '0;
            st_q.valid <= 1'b0;
            st_q.err   <= 1'b0;
            st_q.chan  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.valid;
    assign err_o   = st_q.err;
    assign chan_o  = st_q.chan;

    // R9: strobes are exclusive
    p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_o && err_o));
    // R6: a strobe lasts a single clock
    p_strobe_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o || err_o) |=> !(valid_o || err_o));
    // R6: a strobe only follows the last channel bit
    p_strobe_after_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o || err_o) |-> ($past(st_q.ph) == RX_BITS));
    // R7: a valid grant names a channel that was pending
    p_valid_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ((($past(pend_i) >> chan_o) & N'(1)) != '0));
    // R7: an error grant names a channel that was not pending
    p_err_not_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> ((($past(pend_i) >> chan_o) & N'(1)) == '0));
endmodule

// File: rtl/sdma_agent.sv
module sdma_agent
    import sdma_pkg::*;
#(
    parameter int NUM = NUM_CH
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM-1:0]         chan_req_i,
    output logic                   req_n_o,
    input  logic                   gnt_n_i,
    output logic                   gnt_valid_o,
    output logic [$clog2(NUM)-1:0] gnt_chan_o,
    output logic                   gnt_err_o
);
    sdma_req_ser #(.N(NUM)) u_ser (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (chan_req_i),
        .pin_o (req_n_o)
    );

    sdma_gnt_dec #(.N(NUM)) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (gnt_n_i),
        .pend_i  (chan_req_i),
        .valid_o (gnt_valid_o),
        .chan_o  (gnt_chan_o),
        .err_o   (gnt_err_o)
    );
endmodule

// File: tb/tb_sdma_agent.sv
module tb_sdma_agent;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] chan_req = '0;
    logic       req_n;
    logic       gnt_n = 1'b1;
    logic       gnt_valid;
    logic [2:0] gnt_chan;
    logic       gnt_err;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    sdma_agent dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .chan_req_i  (chan_req),
        .req_n_o     (req_n),
        .gnt_n_i     (gnt_n),
        .gnt_valid_o (gnt_valid),
        .gnt_chan_o  (gnt_chan),
        .gnt_err_o   (gnt_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Sets the requests, then checks the start bit, eight slots and the idle clock.
    task automatic t_frame(input logic [7:0] pat);
        chan_req = pat;
        @(negedge clk);
        chk(req_n == 1'b0, "R2 start", req_n, 0);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk(req_n == pat[i], "R2 slot", req_n, pat[i]);
        end
        @(negedge clk);
        chk(req_n == 1'b1, "R5 idle after frame", req_n, 1);
    endtask

    task automatic t_quiet(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(req_n == 1'b1, req, req_n, 1);
        end
    endtask

    task automatic t_midframe(input logic [7:0] a, input logic [7:0] b);
        chan_req = a;
        @(negedge clk);
        chk(req_n == 1'b0, "R4 first start", req_n, 0);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk(req_n == a[i], "R4 old slot kept", req_n, a[i]);
            if (i == 2) chan_req = b;
        end
        @(negedge clk);
        chk(req_n == 1'b1, "R4 one idle clock", req_n, 1);
        @(negedge clk);
        chk(req_n == 1'b0, "R4 resend start", req_n, 0);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk(req_n == b[i], "R4 new slot", req_n, b[i]);
        end
        @(negedge clk);
        chk(req_n == 1'b1, "R5 idle after resend", req_n, 1);
    endtask

    // The caller drives the start bit low; the task sends b0..b2 and checks the strobe.
    task automatic t_grant(input logic [2:0] ch, input bit exp_ok, input bit chain);
        @(negedge clk) gnt_n = ch[0];
        @(negedge clk) gnt_n = ch[1];
        @(negedge clk) gnt_n = ch[2];
        @(negedge clk);
        if (exp_ok) begin
            chk(gnt_valid == 1'b1, "R6 valid strobe", gnt_valid, 1);
            chk(gnt_chan == ch, "R6 channel", gnt_chan, ch);
            chk(gnt_err == 1'b0, "R9 no err with valid", gnt_err, 0);
        end else begin
            chk(gnt_err == 1'b1, "R7 err strobe", gnt_err, 1);
            chk(gnt_valid == 1'b0, "R7 no valid", gnt_valid, 0);
            chk(gnt_chan == ch, "R7 channel", gnt_chan, ch);
        end
        gnt_n = chain ? 1'b0 : 1'b1;
        if (!chain) begin
            @(negedge clk);
            chk(gnt_valid == 1'b0 && gnt_err == 1'b0, "R6 one clock strobe",
                gnt_valid | gnt_err, 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(req_n == 1'b1, "R1 req pin in reset", req_n, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_n == 1'b1 && !gnt_valid && !gnt_err, "R1 reset outputs",
            {req_n, gnt_valid, gnt_err}, 3'b100);

        t_quiet(12, "R3 no frame for all-zero");
        t_frame(8'hA5);
        t_quiet(12, "R3 no frame when unchanged");
        t_frame(8'h01);
        t_frame(8'h80);
        t_frame(8'h00);
        t_midframe(8'h3C, 8'hC3);

        t_frame(8'h42);
        gnt_n = 1'b0; t_grant(3'd1, 1'b1, 1'b0);
        gnt_n = 1'b0; t_grant(3'd6, 1'b1, 1'b0);
        gnt_n = 1'b0; t_grant(3'd3, 1'b0, 1'b0);
        gnt_n = 1'b0; t_grant(3'd0, 1'b0, 1'b0);
        gnt_n = 1'b0; t_grant(3'd1, 1'b1, 1'b1);
        t_grant(3'd6, 1'b1, 1'b0);   // R9 back-to-back start accepted

        fork
            t_frame(8'h18);
            begin gnt_n = 1'b0; t_grant(3'd4, 1'b1, 1'b0); end   // R8 concurrent
        join
        t_quiet(5, "R5 idle at end");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule